// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a single-port synchronous memory that shares one data bus between reads and writes. Address and control are taken at the rising clock edge. The data for a write follows on the next edge, one cycle after its command. Because of this delayed data phase, a read can follow a write with no idle cycle on the bus.

Every write passes through a one-entry posted buffer. When a new write arrives, the word held in the buffer is committed to the array, and the new address and byte-lane mask take its place. The new data fills the buffer one edge later. A read whose address matches the buffered entry is served from the buffer, with its enabled lanes laid over the array word. This makes the buffering invisible to the user.

Two static mode pins choose one of two read timings, registered or flow-through, and the choice is fixed during reset. Output enable and sleep gate the bus drive asynchronously. The bus is modelled as separate `d_in`, `d_out` and `d_oe` signals.

Top module: `lw_sram`

## Requirements
- R1: Address, select, write enable and byte enables are sampled on the rising edge. The data for a write sampled at edge n is taken from `d_in` at edge n+1.
- R2: `sel_n` high at an edge is a deselect. The bus is not driven in the cycle that holds that edge's read slot: after edge n in flow-through mode, and after edge n+1 in registered mode.
- R3: Back-to-back writes, including two writes to the same address, all land in order. A later read returns the last data written.
- R4: A read that hits the address of the pending buffered write returns the buffered lanes merged over the array word, including a read issued in the cycle right after the write.
- R5: Lane 0 is bits 8:0 with enable `bwe_n[0]`, and lane 1 is bits 17:9 with enable `bwe_n[1]`. Both enables are active low, and only the lanes whose enable is low are written.
- R6: A write with every byte enable high is aborted. Memory contents are left unchanged.
- R7: In registered mode, data for a read sampled at edge n is on the bus after edge n+1. In flow-through mode it is on the bus after edge n.
- R8: An edge that samples a write (aborted or not) leaves the bus undriven for that edge's read slot, so Read-Write-Read needs no idle cycle.
- R9: `oe_n` high forces `d_oe` low without waiting for a clock edge.
- R10: While `sleep` is high, `d_oe` is low and any command sampled at an edge is ignored.
- R11: `mode_sel` is captured while `rst_n` is low. The value 2'b01 selects flow-through, and every other value selects registered. Changes to `mode_sel` after reset have no effect.
- R12: After reset, every word reads as zero, no stale buffer data is forwarded, and `d_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; the mode pins are captured while it is low |
| mode_sel | input | 2 | Static read-timing select |
| sel_n | input | 1 | Active-low synchronous select |
| we_n | input | 1 | Active-low global write enable |
| bwe_n | input | LANES (2) | Active-low per-lane write enables |
| addr | input | ADDR_W (6) | Word address |
| d_in | input | LANES*LANE_W (18) | Write data, one cycle after the command |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous sleep; blocks commands and bus drive |
| d_out | output | LANES*LANE_W (18) | Read data |
| d_oe | output | 1 | Bus drive enable for `d_out` |

## Verification
A wrong buffer address, lane mask or valid bit stays hidden until a read of the same address. A read in the very next cycle exposes it, either through the forwarding merge or after the commit. For this reason the sweeps pair writes with immediate and deferred reads. If a back-to-back write commits the wrong data (the old buffer word in place of the `d_in` that arrives at the same edge), the error appears only at a later read of the first address. The whole-array read-back after each write sweep catches it. Timing faults in the output stage show up within one cycle as `d_oe` asserted or dropped one edge off for the selected mode.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_ABORT = 2'd3
  } op_e;

  typedef enum logic {
    RD_PIPE = 1'b0,
    RD_FLOW = 1'b1
  } rdmode_e;

  // Command decode for one sampled edge.
  function automatic op_e decode_op(input logic sleep, input logic sel_n,
                                    input logic we_n, input logic any_lane);
    op_e r;
    if (sleep || sel_n)  r = OP_NONE;
    else if (we_n)       r = OP_READ;
    else if (any_lane)   r = OP_WRITE;
    else                 r = OP_ABORT;
    return r;
  endfunction

  // Static mode pin decode: only 2'b01 selects flow-through.
  function automatic rdmode_e mode_decode(input logic [1:0] pins);
    return (pins == 2'b01) ? RD_FLOW : RD_PIPE;
  endfunction

endpackage

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [LANES-1:0]         wr_lanes,
  input  logic [LANES*LANE_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [LANES*LANE_W-1:0]  rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en && wr_lanes[l]) begin
        mem[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
      end
    end

    assign rd_data[l*LANE_W +: LANE_W] = mem[rd_addr];
  end

endmodule

// File: rtl/lw_sram_wbuf.sv
module lw_sram_wbuf #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [ADDR_W-1:0]        ld_addr,
  input  logic [LANES-1:0]         ld_lanes,
  input  logic [LANES*LANE_W-1:0]  d_in,
  output logic                     buf_valid,
  output logic                     data_pend,
  output logic [ADDR_W-1:0]        buf_addr,
  output logic [LANES-1:0]         buf_lanes,
  output logic [LANES*LANE_W-1:0]  buf_data,
  output logic                     commit_en,
  output logic [ADDR_W-1:0]        commit_addr,
  output logic [LANES-1:0]         commit_lanes,
  output logic [LANES*LANE_W-1:0]  commit_data
);
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_valid <= 1'b0;
      data_pend <= 1'b0;
      buf_addr  <= '0;
      buf_lanes <= '0;
    end else if (load) begin
      buf_valid <= 1'b1;
      data_pend <= 1'b1;
      buf_addr  <= ld_addr;
      buf_lanes <= ld_lanes;
    end else begin
      data_pend <= 1'b0;
    end
  end

  // Data phase: the word on d_in one edge after its command.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         data_q <= '0;
    else if (data_pend) data_q <= d_in;
  end

  // A new write retires the held entry; on back-to-back writes the held
  // entry's data is the word arriving on d_in at this same edge.
  assign commit_en    = load && buf_valid;
  assign commit_addr  = buf_addr;
  assign commit_lanes = buf_lanes;
  assign commit_data  = data_pend ? d_in : data_q;
  assign buf_data     = data_q;

endmodule

// File: rtl/lw_sram_rdpath.sv
module lw_sram_rdpath #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flow_mode,
  input  logic                     rd_slot,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [LANES*LANE_W-1:0]  arr_data,
  input  logic                     buf_valid,
  input  logic [ADDR_W-1:0]        buf_addr,
  input  logic [LANES-1:0]         buf_lanes,
  input  logic [LANES*LANE_W-1:0]  buf_data,
  output logic                     fwd_hit,
  output logic                     out_valid,
  output logic [LANES*LANE_W-1:0]  out_data
);
  localparam int DATA_W = LANES * LANE_W;

  function automatic logic [DATA_W-1:0] overlay(input logic [DATA_W-1:0] base,
                                                input logic [DATA_W-1:0] top,
                                                input logic [LANES-1:0]  sel);
    logic [DATA_W-1:0] r;
    r = base;
    for (int l = 0; l < LANES; l++)
      if (sel[l]) r[l*LANE_W +: LANE_W] = top[l*LANE_W +: LANE_W];
    return r;
  endfunction

  logic [DATA_W-1:0] rd_word;
  logic              pipe_v;
  logic [DATA_W-1:0] pipe_d;

  assign fwd_hit = buf_valid && (buf_addr == rd_addr);
  assign rd_word = fwd_hit ? overlay(arr_data, buf_data, buf_lanes) : arr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_v <= 1'b0;
      pipe_d <= '0;
    end else begin
      pipe_v <= rd_slot;
      if (rd_slot) pipe_d <= rd_word;
    end
  end

  assign out_valid = flow_mode ? rd_slot : pipe_v;
  assign out_data  = flow_mode ? rd_word : pipe_d;

endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode_sel,
  input  logic                     sel_n,
  input  logic                     we_n,
  input  logic [LANES-1:0]         bwe_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES*LANE_W-1:0]  d_in,
  input  logic                     oe_n,
  input  logic                     sleep,
  output logic [LANES*LANE_W-1:0]  d_out,
  output logic                     d_oe
);
  localparam int DATA_W = LANES * LANE_W;

  rdmode_e            mode_q;
  op_e                op;
  logic               wr_take;
  logic               rd_take;
  logic               rd_slot_q;
  logic [ADDR_W-1:0]  rd_addr_q;
  logic               flow_mode;

  logic               buf_valid, data_pend, commit_en, fwd_hit, out_valid;
  logic [ADDR_W-1:0]  buf_addr, commit_addr;
  logic [LANES-1:0]   buf_lanes, commit_lanes;
  logic [DATA_W-1:0]  buf_data, commit_data, arr_data, out_data;

  // Mode pins are only looked at while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode_decode(mode_sel);
  end
  assign flow_mode = (mode_q == RD_FLOW);

  assign op      = decode_op(sleep, sel_n, we_n, |(~bwe_n));
  assign wr_take = (op == OP_WRITE);
  assign rd_take = (op == OP_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_slot_q <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_slot_q <= rd_take;
      if (rd_take) rd_addr_q <= addr;
    end
  end

  lw_sram_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (wr_take),
    .ld_addr      (addr),
    .ld_lanes     (~bwe_n),
    .d_in         (d_in),
    .buf_valid    (buf_valid),
    .data_pend    (data_pend),
    .buf_addr     (buf_addr),
    .buf_lanes    (buf_lanes),
    .buf_data     (buf_data),
    .commit_en    (commit_en),
    .commit_addr  (commit_addr),
    .commit_lanes (commit_lanes),
    .commit_data  (commit_data)
  );

  lw_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (commit_en),
    .wr_addr  (commit_addr),
    .wr_lanes (commit_lanes),
    .wr_data  (commit_data),
    .rd_addr  (rd_addr_q),
    .rd_data  (arr_data)
  );

  lw_sram_rdpath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_rdpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .flow_mode (flow_mode),
    .rd_slot   (rd_slot_q),
    .rd_addr   (rd_addr_q),
    .arr_data  (arr_data),
    .buf_valid (buf_valid),
    .buf_addr  (buf_addr),
    .buf_lanes (buf_lanes),
    .buf_data  (buf_data),
    .fwd_hit   (fwd_hit),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  assign d_out = out_data;
  assign d_oe  = out_valid && !oe_n && !sleep;

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_n,
  input logic             we_n,
  input logic [LANES-1:0] bwe_n,
  input logic             oe_n,
  input logic             sleep,
  input logic             d_oe,
  input logic             flow_mode,
  input logic             rd_slot,
  input logic             data_pend,
  input logic             buf_valid,
  input logic             commit_en
);
  a_r9_oe_gates_bus: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !d_oe);

  a_r10_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !d_oe);

  a_r8_flow_write_off: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_mode && !sleep && !sel_n && !we_n) |=> !d_oe);

  a_r8_pipe_write_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_mode && !sleep && !sel_n && !we_n) |=> ##1 !d_oe);

  a_r2_flow_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_mode && sel_n) |=> !d_oe);

  a_r2_pipe_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_mode && sel_n) |=> ##1 !d_oe);

  a_r4_read_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    rd_slot |-> !data_pend);

  a_r6_abort_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !we_n && (&bwe_n)) |-> !commit_en);

  a_r10_sleep_holds_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(buf_valid));

  a_r11_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(flow_mode));
endmodule

bind lw_sram lw_sram_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_n     (sel_n),
  .we_n      (we_n),
  .bwe_n     (bwe_n),
  .oe_n      (oe_n),
  .sleep     (sleep),
  .d_oe      (d_oe),
  .flow_mode (flow_mode),
  .rd_slot   (rd_slot_q),
  .data_pend (data_pend),
  .buf_valid (buf_valid),
  .commit_en (commit_en)
);

// File: tb/tb_lw_sram.sv
module tb_lw_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int DW    = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode_sel = 2'b00;
  logic          sel_n = 1'b1, we_n = 1'b1, oe_n = 1'b0, sleep = 1'b0;
  logic [1:0]    bwe_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d_in = '0;
  logic [DW-1:0] d_out;
  logic          d_oe;

  lw_sram dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sel_n(sel_n), .we_n(we_n),
    .bwe_n(bwe_n), .addr(addr), .d_in(d_in), .oe_n(oe_n), .sleep(sleep),
    .d_out(d_out), .d_oe(d_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // Bench model: a flat memory plus the pending write, with the read slots.
  logic [DW-1:0] mdl [DEPTH];
  bit            flow;
  bit            pend;
  int            pend_a;
  logic [1:0]    pend_m;
  logic [DW-1:0] carry;
  bit            now_v, prev_v;
  logic [DW-1:0] now_d, prev_d;

  function automatic logic [DW-1:0] pat(int a, int k);
    return DW'((a * 1031 + k * 4099 + 17) ^ (a << 9));
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw,
                                          logic [1:0] bwe);
    logic [DW-1:0] r;
    r = old;
    if (!bwe[0]) r[8:0]  = nw[8:0];
    if (!bwe[1]) r[17:9] = nw[17:9];
    return r;
  endfunction

  task automatic step(string tag, logic s, logic w, logic [1:0] b, int a,
                      logic oe, logic slp);
    bit exp_v, exp_oe;
    logic [DW-1:0] exp_d;
    sel_n = s; we_n = w; bwe_n = b; addr = AW'(a); oe_n = oe; sleep = slp;
    d_in = carry;
    @(posedge clk);
    if (pend) begin
      mdl[pend_a] = merge(mdl[pend_a], carry, pend_m);
      pend = 0;
    end
    prev_v = now_v; prev_d = now_d;
    now_v = 0;
    if (!slp && !s) begin
      if (w) begin
        now_v = 1; now_d = mdl[a];
      end else if (b != 2'b11) begin
        pend = 1; pend_a = a; pend_m = b;
      end
    end
    @(negedge clk);
    exp_v  = flow ? now_v : prev_v;
    exp_d  = flow ? now_d : prev_d;
    exp_oe = exp_v && !oe && !slp;
    vectors++;
    if (d_oe !== exp_oe) begin
      fails++;
      $display("FAIL %s: d_oe=%0b expected %0b (addr %0d)", tag, d_oe, exp_oe, a);
    end else if (exp_oe && d_out !== exp_d) begin
      fails++;
      $display("FAIL %s: d_out=%05h expected %05h (addr %0d)", tag, d_out, exp_d, a);
    end
  endtask

  task automatic wr(string tag, int a, logic [DW-1:0] d, logic [1:0] b);
    step(tag, 1'b0, 1'b0, b, a, 1'b0, 1'b0);
    carry = d;
  endtask

  task automatic rd(string tag, int a);
    step(tag, 1'b0, 1'b1, 2'b11, a, 1'b0, 1'b0);
  endtask

  task automatic idle(string tag);
    step(tag, 1'b1, 1'b1, 2'b11, 0, 1'b0, 1'b0);
  endtask

  task automatic do_reset(logic [1:0] m);
    rst_n = 1'b0; mode_sel = m;
    sel_n = 1'b1; we_n = 1'b1; bwe_n = 2'b11; oe_n = 1'b0; sleep = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    flow = (m == 2'b01);
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    pend = 0; now_v = 0; prev_v = 0; carry = '0; now_d = '0; prev_d = '0;
    vectors++;
    if (d_oe !== 1'b0) begin
      fails++;
      $display("FAIL R12: d_oe=%0b expected 0 after reset", d_oe);
    end
  endtask

  task automatic run_suite(logic [1:0] m);
    do_reset(m);
    // R12: all words zero, nothing forwarded from an empty buffer
    for (int a = 0; a < DEPTH; a++) rd("R12", a);
    // R3/R1: back-to-back writes over the full array, then read-back (R7)
    for (int a = 0; a < DEPTH; a++) wr("R3", a, pat(a, 1), 2'b00);
    idle("R1");
    for (int a = 0; a < DEPTH; a++) rd("R7", a);
    // R4/R8: write then immediate read of the same address
    for (int a = 0; a < 16; a++) begin
      wr("R8", a * 3, pat(a, 2), 2'b00);
      rd("R4", a * 3);
    end
    // R5: single-lane writes, immediate hit (R4 merge) and later read
    wr("R5", 5, pat(5, 7), 2'b10);
    rd("R4", 5);
    wr("R5", 9, pat(9, 8), 2'b01);
    rd("R4", 9);
    idle("R5");
    rd("R5", 5);
    rd("R5", 9);
    // R6: aborted write leaves contents intact
    wr("R6", 5, 18'h3ffff, 2'b11);
    rd("R6", 5);
    idle("R6");
    rd("R6", 5);
    // R3: same address twice back-to-back
    wr("R3", 12, pat(12, 3), 2'b00);
    wr("R3", 12, pat(12, 4), 2'b00);
    idle("R3");
    rd("R3", 12);
    // R2: deselect between reads
    rd("R2", 1); idle("R2"); rd("R2", 2); idle("R2"); idle("R2"); rd("R2", 3);
    idle("R2");
    // R9: output enable held high during reads
    step("R9", 1'b0, 1'b1, 2'b11, 4, 1'b1, 1'b0);
    step("R9", 1'b0, 1'b1, 2'b11, 6, 1'b1, 1'b0);
    rd("R9", 7);
    // R10: sleep blocks a write and a read, bus off
    step("R10", 1'b0, 1'b0, 2'b00, 20, 1'b0, 1'b1);
    carry = 18'h15a5a;
    step("R10", 1'b0, 1'b1, 2'b11, 20, 1'b0, 1'b1);
    rd("R10", 20);
    idle("R10");
    // R8: read-write-read with every lane mix
    for (int k = 0; k < 4; k++) begin
      rd("R8", 30 + k);
      wr("R8", 30 + k, pat(k, 9), 2'(k));
      rd("R8", 30 + k);
    end
    idle("R8");
    for (int k = 0; k < 4; k++) rd("R5", 30 + k);
    idle("R7");
  endtask

  initial begin
    run_suite(2'b01);
    run_suite(2'b00);
    run_suite(2'b10);
    // R11: mode pins moved after reset must not alter timing
    do_reset(2'b01);
    mode_sel = 2'b00;
    wr("R11", 40, pat(40, 5), 2'b00);
    rd("R11", 40);
    rd("R11", 41);
    idle("R11");
    do_reset(2'b11);
    mode_sel = 2'b01;
    wr("R11", 40, pat(40, 6), 2'b00);
    rd("R11", 40);
    rd("R11", 41);
    idle("R11");
    idle("R11");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule